// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit free-running counter that advances by one on every cycle in which its count-enable input is high. Three event sources are built around it. An input-capture channel copies the count into a holding register when its pin shows the selected edge, or when a separate trigger input pulses. An output-compare channel drives a pin to a programmed level when the count reaches a programmed value. A rollover detector notes each wrap from all ones to zero.

Software reaches the block through a byte-wide register port with eight addresses. Each event has a sticky flag in a status register. A flag clears only after a two-step handshake: a status read that sees the flag set, followed by an access to the register paired with that flag. One interrupt line reports every flag whose enable bit is set.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset, the three interrupt enables and the output-level bit are 0, all flags and the count are 0, the compare register is 0xFFFF, the capture register is 0 and `cmp_pin` is 0.
- R2: The edge-select bit (control bit 1) keeps its value through reset.
- R3: Register map: 0 control, 1 status, 2/3 count high/low, 4/5 capture high/low, 6/7 compare high/low. The count rises by one on each clock with `tick` high and wraps from 0xFFFF to 0.
- R4: A write to the compare high byte (address 6) blocks matching until the compare low byte (address 7) is written.
- R5: When a tick takes the count to the compare value and matching is not blocked, the compare flag (status bit 6) sets and `cmp_pin` takes the output-level bit (control bit 0) on that same clock edge.
- R6: The wrap sets the overflow flag (status bit 5). The flag clears only when a status read that sees it set is followed by a read of the count low byte.
- R7: The compare flag clears only when a status read that sees it set is followed by a write of the compare low byte.
- R8: After a two-flop synchroniser, a rising edge of `cap_pin` (control bit 1 = 1) or a falling edge (bit 1 = 0), or a high `cap_alt`, latches the count into the capture register and sets the capture flag (status bit 7). That flag clears only when a status read that sees it set is followed by a read of the capture low byte.
- R9: A read of the capture high byte holds the capture register unchanged until the capture low byte is read. The capture flag still sets during the hold.
- R10: `irq` is high whenever a flag is set and its enable is 1: control bit 7 for capture, bit 6 for compare, bit 5 for overflow.
- R11: Control bits 4 to 2 and status bits 4 to 0 read as 0. Writes to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one increment per high cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_alt | input | 1 | Synchronous alternate capture trigger |
| cmp_pin | output | 1 | Output-compare pin |
| irq | output | 1 | Interrupt request |

## Verification
The compare is tried three ways: a value reached while matching is blocked, the same kind of value reached after the low byte is written, and a low-byte write made with no prior status read. Together these separate the blocking from the flag handshake. The capture is driven by a rising pin edge, a falling pin edge under each polarity, and alternate-trigger pulses given while the register is held, so polarity, the synchroniser delay and the hold are each seen on their own. The overflow run covers a full wrap and then tries the clear order both wrong and right.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int REG_AW = 3;
  localparam int NFLAGS = 3;

  // flag / enable indices
  localparam int F_CAP = 0;
  localparam int F_CMP = 1;
  localparam int F_OVF = 2;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_CNTH = 3'd2,
    A_CNTL = 3'd3,
    A_CAPH = 3'd4,
    A_CAPL = 3'd5,
    A_CMPH = 3'd6,
    A_CMPL = 3'd7
  } reg_addr_e;

  // Edge qualifier: rise_sel=1 picks 0->1, otherwise 1->0.
  function automatic logic active_edge(input logic rise_sel, input logic now_v,
                                       input logic before_v);
    return rise_sel ? (now_v & ~before_v) : (~now_v & before_v);
  endfunction

  // Places the three per-flag bits at 7/6/5 with the low five bits zero.
  function automatic logic [7:0] top3(input logic [NFLAGS-1:0] v);
    return {v[F_CAP], v[F_CMP], v[F_OVF], 5'b00000};
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic [NFLAGS-1:0] ien,
                                           input logic edge_sel, input logic lvl);
    logic [7:0] b;
    b = top3(ien);
    b[1] = edge_sel;
    b[0] = lvl;
    return b;
  endfunction

  function automatic logic [NFLAGS-1:0] ien_from_byte(input logic [7:0] b);
    logic [NFLAGS-1:0] v;
    v[F_CAP] = b[7];
    v[F_CMP] = b[6];
    v[F_OVF] = b[5];
    return v;
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next,
  output logic          wrap
);

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic en);
    return en ? c + 1'b1 : c;
  endfunction

  assign count_next = step(count, tick);
  assign wrap       = tick && (count == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_next;
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == CW'($past(count) + 1'b1)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          alt,
  input  logic          rise_sel,
  input  logic [CW-1:0] count,
  input  logic          rd_hi,
  input  logic          rd_lo,
  output logic [CW-1:0] cap_val,
  output logic          cap_event,
  output logic          frozen
);

  // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;
  logic                 pin_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], pin};
  end

  assign pin_edge  = active_edge(rise_sel, chain[SYNC_STAGES-1], chain[SYNC_STAGES]);
  assign cap_event = pin_edge | alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cap_val <= '0;
    else if (cap_event && !frozen)  cap_val <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frozen <= 1'b0;
    else if (rd_hi) frozen <= 1'b1;
    else if (rd_lo) frozen <= 1'b0;
  end

  a_r8_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_event && !frozen) |=> (cap_val == $past(count)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(cap_val));

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] count_next,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [7:0]    wdata,
  input  logic          lvl,
  output logic [CW-1:0] cmp_val,
  output logic          inhibit,
  output logic          hit,
  output logic          pin
);

  localparam int HI_W = CW - 8;

  function automatic logic match(input logic en, input logic blk,
                                 input logic [CW-1:0] a, input logic [CW-1:0] b);
    return en && !blk && (a == b);
  endfunction

  assign hit = match(tick, inhibit, count_next, cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '1;
      inhibit <= 1'b0;
    end else if (wr_hi) begin
      cmp_val[CW-1:8] <= wdata[HI_W-1:0];
      inhibit         <= 1'b1;
    end else if (wr_lo) begin
      cmp_val[7:0] <= wdata;
      inhibit      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pin <= 1'b0;
    else if (hit) pin <= lvl;
  end

  a_r5_pin_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin) |-> $past(hit));
  a_r4_low_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> !inhibit);

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic status_rd,
  input  logic pair_acc,
  output logic flag,
  output logic armed
);

  logic clr;
  assign clr = armed && pair_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (clr)       armed <= 1'b0;
    else if (status_rd) armed <= flag;
  end

  // R6, R7, R8: a flag only drops after the status-read then paired-access order
  a_r7_clear_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && pair_acc));

endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cap_pin,
  input  logic              cap_alt,
  output logic              cmp_pin,
  output logic              irq
);

  reg_addr_e adr;
  assign adr = reg_addr_e'(reg_addr);

  // decoded accesses
  logic wr_ctrl, wr_stat, wr_cmph, wr_cmpl;
  logic rd_stat, rd_cntl, rd_caph, rd_capl;
  assign wr_ctrl = reg_wr && (adr == A_CTRL);
  assign wr_stat = reg_wr && (adr == A_STAT);
  assign wr_cmph = reg_wr && (adr == A_CMPH);
  assign wr_cmpl = reg_wr && (adr == A_CMPL);
  assign rd_stat = reg_rd && (adr == A_STAT);
  assign rd_cntl = reg_rd && (adr == A_CNTL);
  assign rd_caph = reg_rd && (adr == A_CAPH);
  assign rd_capl = reg_rd && (adr == A_CAPL);

  // control register
  logic [NFLAGS-1:0] ien;
  logic              edge_sel;
  logic              out_lvl;
  logic              unused_wbits;
  assign unused_wbits = ^reg_wdata[4:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      out_lvl <= 1'b0;
    end else if (wr_ctrl) begin
      ien     <= ien_from_byte(reg_wdata);
      out_lvl <= reg_wdata[0];
    end
  end

  // edge select deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (wr_ctrl) edge_sel <= reg_wdata[1];
  end

  // datapath
  logic [CW-1:0] count, count_next, cap_val, cmp_val;
  logic          wrap, cap_event, cap_frozen, cmp_hit, cmp_inhibit;

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .count(count), .count_next(count_next), .wrap(wrap)
  );

  tmr_capture #(.CW(CW), .SYNC_STAGES(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .alt(cap_alt),
    .rise_sel(edge_sel), .count(count), .rd_hi(rd_caph), .rd_lo(rd_capl),
    .cap_val(cap_val), .cap_event(cap_event), .frozen(cap_frozen)
  );

  tmr_compare #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_next(count_next),
    .wr_hi(wr_cmph), .wr_lo(wr_cmpl), .wdata(reg_wdata), .lvl(out_lvl),
    .cmp_val(cmp_val), .inhibit(cmp_inhibit), .hit(cmp_hit), .pin(cmp_pin)
  );

  // flags
  logic [NFLAGS-1:0] flag_set, flag_pair, flags, armed;
  assign flag_set[F_CAP]  = cap_event;
  assign flag_set[F_CMP]  = cmp_hit;
  assign flag_set[F_OVF]  = wrap;
  assign flag_pair[F_CAP] = rd_capl;
  assign flag_pair[F_CMP] = wr_cmpl;
  assign flag_pair[F_OVF] = rd_cntl;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    tmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[i]), .status_rd(rd_stat),
      .pair_acc(flag_pair[i]), .flag(flags[i]), .armed(armed[i])
    );
  end

  assign irq = |(flags & ien);

  // read mux
  always_comb begin
    unique case (adr)
      A_CTRL:  reg_rdata = ctrl_byte(ien, edge_sel, out_lvl);
      A_STAT:  reg_rdata = top3(flags);
      A_CNTH:  reg_rdata = count[CW-1:8];
      A_CNTL:  reg_rdata = count[7:0];
      A_CAPH:  reg_rdata = cap_val[CW-1:8];
      A_CAPL:  reg_rdata = cap_val[7:0];
      A_CMPH:  reg_rdata = cmp_val[CW-1:8];
      A_CMPL:  reg_rdata = cmp_val[7:0];
      default: reg_rdata = '0;
    endcase
  end

  a_r4_blocked_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_inhibit && !flags[F_CMP]) |=> !flags[F_CMP]);
  a_r11_stat_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (flag_set == '0)) |=> $stable(flags));
  a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[F_OVF]);

endmodule

// File: tb/tmr_capcmp_tb.sv
module tmr_capcmp_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, tick, reg_rd, reg_wr, cap_pin, cap_alt;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cmp_pin, irq;

  tmr_capcmp u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_pin(cap_pin), .cap_alt(cap_alt), .cmp_pin(cmp_pin), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] m_cnt, m_cap, m_cmp;
  bit          m_frz, m_inh, m_out, m_olvl, m_edg;
  bit          m_ecap, m_ecmp, m_eovf;
  bit          m_f[3];   // 0 capture, 1 compare, 2 overflow
  bit          m_arm[3];
  bit          hist[$];
  bit          run_cmp = 1'b0;

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0: return {m_ecap, m_ecmp, m_eovf, 3'b000, m_edg, m_olvl};
      1: return {m_f[0], m_f[1], m_f[2], 5'b00000};
      2: return m_cnt[15:8];
      3: return m_cnt[7:0];
      4: return m_cap[15:8];
      5: return m_cap[7:0];
      6: return m_cmp[15:8];
      default: return m_cmp[7:0];
    endcase
  endfunction

  function automatic bit m_irq();
    return (m_f[0] && m_ecap) || (m_f[1] && m_ecmp) || (m_f[2] && m_eovf);
  endfunction

  always @(posedge clk) begin : upd
    logic [15:0] nx;
    bit ev, hit, ovf, st_rd;
    bit setv[3];
    bit pair[3];
    bit nf[3];
    bit na[3];
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_cmp = 16'hFFFF;
      m_frz = 0; m_inh = 0; m_out = 0; m_olvl = 0;
      m_ecap = 0; m_ecmp = 0; m_eovf = 0;
      for (int i = 0; i < 3; i++) begin m_f[i] = 0; m_arm[i] = 0; end
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      nx    = tick ? m_cnt + 16'd1 : m_cnt;
      ovf   = tick && (m_cnt == 16'hFFFF);
      hit   = tick && !m_inh && (nx == m_cmp);
      ev    = cap_alt || (m_edg ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]));
      st_rd = reg_rd && (reg_addr == 3'd1);
      setv[0] = ev; setv[1] = hit; setv[2] = ovf;
      pair[0] = reg_rd && (reg_addr == 3'd5);
      pair[1] = reg_wr && (reg_addr == 3'd7);
      pair[2] = reg_rd && (reg_addr == 3'd3);
      for (int i = 0; i < 3; i++) begin
        nf[i] = setv[i] ? 1'b1 : ((m_arm[i] && pair[i]) ? 1'b0 : m_f[i]);
        na[i] = (m_arm[i] && pair[i]) ? 1'b0 : (st_rd ? m_f[i] : m_arm[i]);
      end
      for (int i = 0; i < 3; i++) begin m_f[i] = nf[i]; m_arm[i] = na[i]; end
      if (hit) m_out = m_olvl;
      if (ev && !m_frz) m_cap = m_cnt;
      if (reg_rd && reg_addr == 3'd4) m_frz = 1;
      else if (reg_rd && reg_addr == 3'd5) m_frz = 0;
      if (reg_wr && reg_addr == 3'd6) begin m_cmp[15:8] = reg_wdata; m_inh = 1; end
      if (reg_wr && reg_addr == 3'd7) begin m_cmp[7:0] = reg_wdata; m_inh = 0; end
      if (reg_wr && reg_addr == 3'd0) begin
        m_ecap = reg_wdata[7]; m_ecmp = reg_wdata[6]; m_eovf = reg_wdata[5];
        m_olvl = reg_wdata[0];
      end
      m_cnt = nx;
    end
    if (reg_wr && reg_addr == 3'd0) m_edg = reg_wdata[1];
    if (rst_n) begin
      hist.push_front(cap_pin);
      void'(hist.pop_back());
    end
  end

  // per-clock comparison of the pins
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      check("R10 irq", irq, m_irq());
      check("R5 cmp_pin", cmp_pin, m_out);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reg_rd = 0; reg_wr = 0; cap_alt = 0;
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_rd = 0; reg_wr = 1; reg_addr = a; reg_wdata = d; cap_alt = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input string req, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1; reg_wr = 0; reg_addr = a; cap_alt = 0;
    #2;
    v = reg_rdata;
    check(req, v, m_read(a));
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0]  v;
  logic [15:0] t;

  initial begin
    rst_n = 0; tick = 0; cap_pin = 0; cap_alt = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wr_reg(3'd0, 8'h02);              // rising edge select
    idle(1);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;

    // R1, R2 reset state
    rd_reg(3'd0, "R2 ctrl after reset", v); check("R2 edge kept", v, 8'h02);
    rd_reg(3'd1, "R1 stat", v);  check("R1 stat zero", v, 8'h00);
    rd_reg(3'd2, "R1 cnt hi", v); check("R1 cnt hi", v, 8'h00);
    rd_reg(3'd3, "R1 cnt lo", v); check("R1 cnt lo", v, 8'h00);
    rd_reg(3'd6, "R1 cmp hi", v); check("R1 cmp hi", v, 8'hFF);
    rd_reg(3'd7, "R1 cmp lo", v); check("R1 cmp lo", v, 8'hFF);
    rd_reg(3'd5, "R1 cap lo", v); check("R1 cap lo", v, 8'h00);
    check("R1 cmp_pin", cmp_pin, 0);

    // R11 unimplemented bits, status write ignored
    wr_reg(3'd0, 8'hFF);
    rd_reg(3'd0, "R11 ctrl", v); check("R11 ctrl mask", v, 8'hE3);
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, "R11 stat", v); check("R11 stat write ignored", v, 8'h00);

    // R3 counting
    tick = 1; idle(37); tick = 0;
    rd_reg(3'd3, "R3 cnt lo", v);
    rd_reg(3'd2, "R3 cnt hi", v);
    tick = 1; idle(300); tick = 0;
    rd_reg(3'd3, "R3 cnt lo after 300", v);
    rd_reg(3'd2, "R3 cnt hi after 300", v); check("R3 cnt hi advanced", v, 8'h01);

    // R4 blocked compare
    t = m_cnt + 16'd8;
    wr_reg(3'd7, t[7:0]);
    wr_reg(3'd6, t[15:8]);
    tick = 1; idle(20); tick = 0;
    rd_reg(3'd1, "R4 stat", v); check("R4 no match while blocked", v & 8'h40, 0);
    check("R4 pin idle", cmp_pin, 0);

    // R5 released compare
    t = m_cnt + 16'd8;
    wr_reg(3'd6, t[15:8]);
    wr_reg(3'd7, t[7:0]);
    tick = 1; idle(20); tick = 0;
    check("R5 pin level", cmp_pin, 1);
    check("R10 irq on cmp", irq, 1);

    // R7 clear order
    wr_reg(3'd7, t[7:0]);
    rd_reg(3'd1, "R7 stat", v); check("R7 not cleared without status read", v & 8'h40, 8'h40);
    wr_reg(3'd7, t[7:0]);
    rd_reg(3'd1, "R7 stat2", v); check("R7 cleared", v & 8'h40, 0);

    // R6 overflow
    tick = 1; idle(int'(16'hFFFF - m_cnt) + 4); tick = 0;
    rd_reg(3'd3, "R6 cnt lo", v);
    rd_reg(3'd1, "R6 stat", v); check("R6 ovf set", v & 8'h20, 8'h20);
    rd_reg(3'd3, "R6 cnt lo clr", v);
    rd_reg(3'd1, "R6 stat2", v); check("R6 ovf cleared", v & 8'h20, 0);
    wr_reg(3'd7, t[7:0]);     // flush any compare flag from the wrap pass
    rd_reg(3'd1, "R7 stat3", v);
    wr_reg(3'd7, t[7:0]);

    // R8 rising capture
    tick = 1;
    @(negedge clk); cap_pin = 1;
    idle(5); tick = 0;
    rd_reg(3'd1, "R8 stat", v); check("R8 rise flag", v & 8'h80, 8'h80);
    rd_reg(3'd4, "R8 cap hi", v);
    rd_reg(3'd5, "R8 cap lo clr", v);
    rd_reg(3'd1, "R8 stat2", v); check("R8 cleared", v & 8'h80, 0);

    // R9 hold
    tick = 1; idle(10);
    rd_reg(3'd4, "R9 cap hi", v);
    idle(3);
    @(negedge clk); cap_alt = 1;
    idle(3); tick = 0;
    rd_reg(3'd1, "R9 stat", v); check("R9 flag during hold", v & 8'h80, 8'h80);
    rd_reg(3'd5, "R9 cap lo held", v);
    tick = 1;
    @(negedge clk); cap_alt = 1;
    idle(2); tick = 0;
    rd_reg(3'd4, "R9 cap hi new", v);
    rd_reg(3'd5, "R9 cap lo new", v);

    // R8 falling polarity
    wr_reg(3'd0, 8'hE1);
    rd_reg(3'd1, "R8 stat3", v);
    rd_reg(3'd5, "R8 clr", v);
    tick = 1;
    @(negedge clk); cap_pin = 0;
    idle(5);
    rd_reg(3'd1, "R8 fall", v); check("R8 fall flag", v & 8'h80, 8'h80);
    rd_reg(3'd5, "R8 fall cap", v);
    @(negedge clk); cap_pin = 1;
    idle(5); tick = 0;
    rd_reg(3'd1, "R8 rise ignored", v); check("R8 rise ignored when falling", v & 8'h80, 0);

    // R10 enables
    @(negedge clk); cap_alt = 1;
    idle(2);
    check("R10 irq enabled", irq, 1);
    wr_reg(3'd0, 8'h01);
    idle(2);
    check("R10 irq masked", irq, 0);

    run_cmp = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule